// File: doc/BRIEF.md
# SPI Master with Register Interface

This block is a single-slave SPI master that software drives through five word-wide registers on a plain synchronous bus: address, write strobe and write data in, with read data returned combinationally for the presented address. Software raises and drops the slave select by hand through a control bit. It chooses the clock polarity, the clock phase, the word length (8 or 16 bits) and a coded SCK divider through a configuration register.

A write to the transmit register launches exactly one full-duplex word. The word leaves on MOSI most significant bit first, and the bits arriving on MISO are collected at the same time. When the last bit is in, the collected word lands in the receive register and a completion flag is raised in the cause register, both on the same clock edge. Software clears the flag by writing a zero to it before it starts the next word. Bit 1 of the cause register shows that a word is still on the wire.

Top module: `spim_top`

## Requirements
- R1: After reset every register reads 0, the slave select output is high (released), SCK is low and MOSI is low.
- R2: Bit 0 of the control register (offset 0x00) drives slave select, active low: writing 1 pulls the select output low and writing 0 releases it. A word transfer never changes it.
- R3: The configuration register (offset 0x04) holds the prescale code in bits [4:0], word length in bit 5 (0 = 8 bits, 1 = 16 bits), CPOL in bit 11 and CPHA in bit 12. These bits read back as written and every other bit reads 0.
- R4: A prescale code C from 0x12 to 0x1F gives an SCK half period of C-16 core clocks, which is a divide ratio of 2*(C-16). Any code below 0x12 acts as a half period of 2 core clocks (divide by 4).
- R5: While no word is moving, SCK sits at the CPOL level, one clock after the configuration write. A word of W bits makes exactly W SCK pulses and leaves SCK back at the CPOL level.
- R6: Data goes out MSB first. With CPHA = 0 the first bit is on MOSI from the clock after the start, later bits change on trailing SCK edges and MISO is sampled on leading edges. With CPHA = 1 each bit changes on a leading edge and MISO is sampled on trailing edges.
- R7: A write to the transmit register (offset 0x08) starts one word made of the low 8 or low 16 bits of the write data. The word lasts 2*W*H core clocks, where H is the half period.
- R8: On the closing edge of a word, the receive register (offset 0x0C) takes the received word, zero-extended, and the cause register (offset 0x10) bit 0 goes to 1. On that same edge the busy bit 1 drops to 0.
- R9: A write to the cause register with bit 0 = 0 clears the completion flag. A write with bit 0 = 1 leaves the flag as it was.
- R10: A write to the transmit register while busy is ignored, and the word already in flight continues unchanged.
- R11: MOSI is held low whenever no word is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the slave |
| spi_miso | input | 1 | Serial data from the slave |
| spi_ss_n | output | 1 | Slave select, active low |

## Verification
The hardest case to reach from the ports is a transmit write that lands in the middle of a word: the SCK counter and the shift position must carry on as if the write had not happened. The bench issues a second transmit write seven cycles into a slow 16-bit mode-3 word and compares SCK and MOSI against its own model on every cycle. It also drives MISO from a behavioural slave that follows the same phase schedule, so a wrong sampling edge or a shifted bit shows up in the received word. Codes below the legal prescale range are exercised by timing how long the busy bit stays up.

// File: rtl/spim_pkg.sv
package spim_pkg;
   // register byte offsets, decoded by software
   localparam int OFS_CTRL  = 'h00;
   localparam int OFS_CFG   = 'h04;
   localparam int OFS_TX    = 'h08;
   localparam int OFS_RX    = 'h0C;
   localparam int OFS_CAUSE = 'h10;

   // configuration field positions
   localparam int CFG_PRESC_LSB = 0;
   localparam int CFG_WIDE_BIT  = 5;
   localparam int CFG_CPOL_BIT  = 11;
   localparam int CFG_CPHA_BIT  = 12;

   // prescale code width
   localparam int PRESC_W = 5;

   typedef struct packed {
      logic               cpha;
      logic               cpol;
      logic               wide;
      logic [PRESC_W-1:0] presc;
   } spim_cfg_t;
endpackage

// File: rtl/spim_clkdiv.sv
module spim_clkdiv #(
   parameter int PRESC_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [PRESC_W-1:0] presc,
   output logic               tick
);
   localparam int HW = PRESC_W - 1;
   localparam logic [PRESC_W-1:0] BASE_CODE = PRESC_W'(1 << HW);
   localparam logic [PRESC_W-1:0] MIN_CODE  = BASE_CODE + PRESC_W'(2);

   logic [HW-1:0] half;
   logic [HW-1:0] cnt;

   initial begin : elab_chk
      assert (PRESC_W >= 3) else $error("PRESC_W too small");
   end

   // codes under the legal floor fall back to a half period of two
   always_comb half = (presc < MIN_CODE) ? HW'(2) : presc[HW-1:0];

   assign tick = run && (cnt == half - HW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!run || tick)   cnt <= '0;
      else                     cnt <= cnt + HW'(1);
   end

   // two edge events are never adjacent: SCK is at most clk/4
   AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R4
endmodule

// File: rtl/spim_shift.sv
module spim_shift
   import spim_pkg::*;
#(
   parameter int WMAX = 16,
   parameter int WMIN = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  spim_cfg_t       cfg,
   input  logic            start,
   input  logic [WMAX-1:0] tx_word,
   input  logic            miso,
   output logic            busy,
   output logic            sck,
   output logic            mosi,
   output logic            fin,
   output logic [WMAX-1:0] rx_fin
);
   localparam int ECW = $clog2(2*WMAX + 1);
   localparam logic [ECW-1:0] EDGES_WIDE   = ECW'(2*WMAX);
   localparam logic [ECW-1:0] EDGES_NARROW = ECW'(2*WMIN);

   logic               busy_q, ph_q, mosi_q;
   logic [ECW-1:0]     ecnt;
   logic [WMAX-1:0]    txsh, rxsh, rx_next, rx_pick, aligned;
   logic               run_cpol, run_cpha, run_wide;
   logic [PRESC_W-1:0] run_presc;
   logic               tick, leading, last, do_launch, do_sample;
   logic [ECW-1:0]     total;

   initial begin : elab_chk
      assert (WMAX > WMIN && WMIN >= 2) else $error("bad word widths");
   end

   spim_clkdiv #(.PRESC_W(PRESC_W)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .presc (run_presc),
      .tick  (tick)
   );

   always_comb begin
      total     = run_wide ? EDGES_WIDE : EDGES_NARROW;
      leading   = !ph_q;
      last      = tick && (ecnt + ECW'(1) == total);
      do_launch = tick && (run_cpha ? leading : (!leading && !last));
      do_sample = tick && (run_cpha ? !leading : leading);
      rx_next   = {rxsh[WMAX-2:0], miso};
      rx_pick   = do_sample ? rx_next : rxsh;
      aligned   = cfg.wide ? tx_word
                           : {tx_word[WMIN-1:0], {(WMAX-WMIN){1'b0}}};
   end

   // narrow words keep only their low bits in the captured value
   for (genvar gi = 0; gi < WMAX; gi++) begin : g_rxcap
      if (gi < WMIN) begin : g_low
         assign rx_fin[gi] = rx_pick[gi];
      end else begin : g_high
         assign rx_fin[gi] = run_wide & rx_pick[gi];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         ph_q      <= 1'b0;
         mosi_q    <= 1'b0;
         ecnt      <= '0;
         txsh      <= '0;
         rxsh      <= '0;
         run_cpol  <= 1'b0;
         run_cpha  <= 1'b0;
         run_wide  <= 1'b0;
         run_presc <= '0;
      end else begin
         if (!busy_q) run_cpol <= cfg.cpol;
         if (start && !busy_q) begin
            busy_q    <= 1'b1;
            ph_q      <= 1'b0;
            ecnt      <= '0;
            rxsh      <= '0;
            run_cpha  <= cfg.cpha;
            run_wide  <= cfg.wide;
            run_presc <= cfg.presc;
            if (cfg.cpha) begin
               mosi_q <= 1'b0;
               txsh   <= aligned;
            end else begin
               mosi_q <= aligned[WMAX-1];
               txsh   <= aligned << 1;
            end
         end else if (tick) begin
            ph_q <= ~ph_q;
            ecnt <= ecnt + ECW'(1);
            if (do_launch) begin
               mosi_q <= txsh[WMAX-1];
               txsh   <= txsh << 1;
            end
            if (do_sample) rxsh <= rx_next;
            if (last) begin
               busy_q <= 1'b0;
               mosi_q <= 1'b0;
            end
         end
      end
   end

   assign busy = busy_q;
   assign sck  = run_cpol ^ ph_q;
   assign mosi = mosi_q;
   assign fin  = last;

   AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !mosi_q); // R11
   AST_SCK_HOME: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> (sck == run_cpol)); // R5
endmodule

// File: rtl/spim_regs.sv
module spim_regs
   import spim_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int WMAX   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              busy,
   input  logic              fin,
   input  logic [WMAX-1:0]   rx_fin,
   output spim_cfg_t         cfg,
   output logic              cs_on,
   output logic              start,
   output logic [WMAX-1:0]   tx_word,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   logic hit_ctrl, hit_cfg, hit_tx, hit_rx, hit_cause;
   logic              ctrl_q, done_q;
   spim_cfg_t         cfg_q;
   logic [WMAX-1:0]   rx_q;

   assign hit_ctrl  = (addr == ADDR_W'(OFS_CTRL));
   assign hit_cfg   = (addr == ADDR_W'(OFS_CFG));
   assign hit_tx    = (addr == ADDR_W'(OFS_TX));
   assign hit_rx    = (addr == ADDR_W'(OFS_RX));
   assign hit_cause = (addr == ADDR_W'(OFS_CAUSE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= 1'b0;
         cfg_q  <= '0;
         done_q <= 1'b0;
         rx_q   <= '0;
      end else begin
         if (wr && hit_ctrl) ctrl_q <= wdata[0];
         if (wr && hit_cfg) begin
            cfg_q.presc <= wdata[CFG_PRESC_LSB +: PRESC_W];
            cfg_q.wide  <= wdata[CFG_WIDE_BIT];
            cfg_q.cpol  <= wdata[CFG_CPOL_BIT];
            cfg_q.cpha  <= wdata[CFG_CPHA_BIT];
         end
         // completion has priority over a clearing write
         if (fin) begin
            done_q <= 1'b1;
            rx_q   <= rx_fin;
         end else if (wr && hit_cause) begin
            done_q <= done_q & wdata[0];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (hit_ctrl) rdata[0] = ctrl_q;
      if (hit_cfg) begin
         rdata[CFG_PRESC_LSB +: PRESC_W] = cfg_q.presc;
         rdata[CFG_WIDE_BIT]             = cfg_q.wide;
         rdata[CFG_CPOL_BIT]             = cfg_q.cpol;
         rdata[CFG_CPHA_BIT]             = cfg_q.cpha;
      end
      if (hit_rx) rdata[WMAX-1:0] = rx_q;
      if (hit_cause) begin
         rdata[0] = done_q;
         rdata[1] = busy;
      end
   end

   assign cfg     = cfg_q;
   assign cs_on   = ctrl_q;
   assign start   = wr && hit_tx;
   assign tx_word = wdata[WMAX-1:0];
   assign done    = done_q;
endmodule

// File: rtl/spim_top.sv
module spim_top
   import spim_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 5,
   parameter int WMAX   = 16,
   parameter int WMIN   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              spi_sck,
   output logic              spi_mosi,
   input  logic              spi_miso,
   output logic              spi_ss_n
);
   initial begin : elab_chk
      assert (DATA_W > CFG_CPHA_BIT && DATA_W >= WMAX) else $error("DATA_W too small");
      assert (ADDR_W >= $clog2(OFS_CAUSE + 1)) else $error("ADDR_W too small");
   end

   spim_cfg_t       cfg;
   logic            cs_on, start, busy, fin, done;
   logic [WMAX-1:0] tx_word, rx_fin;

   spim_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WMAX(WMAX)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (bus_addr),
      .wr      (bus_wr),
      .wdata   (bus_wdata),
      .busy    (busy),
      .fin     (fin),
      .rx_fin  (rx_fin),
      .cfg     (cfg),
      .cs_on   (cs_on),
      .start   (start),
      .tx_word (tx_word),
      .rdata   (bus_rdata),
      .done    (done)
   );

   spim_shift #(.WMAX(WMAX), .WMIN(WMIN)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfg     (cfg),
      .start   (start),
      .tx_word (tx_word),
      .miso    (spi_miso),
      .busy    (busy),
      .sck     (spi_sck),
      .mosi    (spi_mosi),
      .fin     (fin),
      .rx_fin  (rx_fin)
   );

   assign spi_ss_n = ~cs_on;

   AST_SS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(bus_wr && bus_addr == ADDR_W'(OFS_CTRL))) |=> $stable(spi_ss_n)); // R2
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done); // R8
endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        spi_sck, spi_mosi, spi_ss_n;
   logic        spi_miso = 1'b0;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // behavioural model state
   int m_ctrl = 0, m_cfg = 0, m_done = 0, m_busy = 0, m_j = 0;
   int m_H = 2, m_W = 8, m_cpha = 0, m_cpol_run = 0;
   int m_tx = 0, m_sl = 0, m_rx = 0;
   int slave_word = 0;

   always #5 clk = ~clk;

   spim_top u_dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
      .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_ss_n(spi_ss_n)
   );

   function automatic int half_of(input int code);
      return (code < 'h12) ? 2 : code - 16;
   endfunction

   function automatic int toggles();
      return m_busy ? m_j / m_H : 0;
   endfunction

   function automatic int bit_at(input int word);
      int c = toggles();
      int idx;
      if (!m_busy) return 0;
      if (m_cpha == 0) idx = c / 2;
      else begin
         if (c == 0) return 0;
         idx = (c + 1) / 2 - 1;
      end
      return (word >> (m_W - 1 - idx)) & 1;
   endfunction

   function automatic int model_read(input int a);
      case (a)
         'h00: return m_ctrl;
         'h04: return m_cfg;
         'h0C: return m_rx;
         'h10: return (m_busy << 1) | m_done;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      int was_busy;
      int fin;
      if (!rst_n) begin
         m_ctrl = 0; m_cfg = 0; m_done = 0; m_busy = 0; m_j = 0;
         m_cpol_run = 0; m_rx = 0;
      end else begin
         was_busy = m_busy;
         fin = 0;
         if (!was_busy) m_cpol_run = (m_cfg >> 11) & 1;
         if (was_busy) begin
            m_j++;
            if (m_j == 2 * m_W * m_H) begin
               m_busy = 0; m_done = 1; m_rx = m_sl; fin = 1;
            end
         end
         if (bus_wr) begin
            case (int'(bus_addr))
               'h00: m_ctrl = bus_wdata[0];
               'h04: m_cfg = int'(bus_wdata) & 'h183F;
               'h08: if (!was_busy) begin
                  m_busy = 1; m_j = 0;
                  m_W = ((m_cfg >> 5) & 1) ? 16 : 8;
                  m_H = half_of(m_cfg & 'h1F);
                  m_cpha = (m_cfg >> 12) & 1;
                  m_tx = int'(bus_wdata) & ((1 << m_W) - 1);
                  m_sl = slave_word & ((1 << m_W) - 1);
               end
               'h10: if (!fin) m_done = m_done & int'(bus_wdata[0]);
               default: ;
            endcase
         end
      end
   end

   // slave drive and per-cycle comparison
   always @(negedge clk) begin
      spi_miso = bit_at(m_sl)[0];
      if (rst_n && !finished) begin
         total++;
         if (spi_sck !== 1'((m_cpol_run ^ (toggles() & 1)))) begin
            bad++; $display("FAIL R5 sck act=%b exp=%0d t=%0t", spi_sck, m_cpol_run ^ (toggles() & 1), $time);
         end
         total++;
         if (spi_mosi !== 1'(bit_at(m_tx))) begin
            bad++; $display("FAIL R6 mosi act=%b exp=%0d t=%0t", spi_mosi, bit_at(m_tx), $time);
         end
         total++;
         if (spi_ss_n !== 1'(!m_ctrl)) begin
            bad++; $display("FAIL R2 ss_n act=%b exp=%0d t=%0t", spi_ss_n, !m_ctrl, $time);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++; $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      bus_addr = 5'(a); bus_wr = 1'b1; bus_wdata = 32'(d);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input string req, input int a, input int exp);
      @(negedge clk);
      bus_addr = 5'(a);
      #1;
      check(req, int'(bus_rdata), exp);
      check({req, " model"}, int'(bus_rdata), model_read(a));
   endtask

   // start a word and count cycles until the busy bit drops
   task automatic timed_word(input string req, input int d, input int exp_cycles);
      int n = 0;
      wr('h08, d);
      bus_addr = 5'h10;
      #1;
      while (bus_rdata[1]) begin
         @(negedge clk); #1; n++;
      end
      check(req, n, exp_cycles);
   endtask

   task automatic summary();
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         bad++; $display("FAIL watchdog expired");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 sck", int'(spi_sck), 0);
      check("R1 mosi", int'(spi_mosi), 0);
      check("R1 ss_n", int'(spi_ss_n), 1);
      rd("R1 ctrl", 'h00, 0);
      rd("R1 cfg", 'h04, 0);
      rd("R1 rx", 'h0C, 0);
      rd("R1 cause", 'h10, 0);

      // R3 field readback
      wr('h04, 'hFFFF_FFFF);
      rd("R3 cfg all ones", 'h04, 'h183F);

      // R2 manual select
      wr('h00, 1);
      check("R2 ss low", int'(spi_ss_n), 0);
      rd("R2 ctrl", 'h00, 1);

      // mode 0, 8 bit, half period 2; R7 low byte only
      wr('h04, 'h12);
      slave_word = 'hA5;
      timed_word("R7 8b duration", 'h13C, 32);
      rd("R8 rx 8b", 'h0C, 'hA5);
      rd("R8 cause done", 'h10, 1);
      check("R2 ss held", int'(spi_ss_n), 0);

      // R9 clear semantics
      wr('h10, 1);
      rd("R9 keep", 'h10, 1);
      wr('h10, 0);
      rd("R9 clear", 'h10, 0);

      // mode 3, 16 bit, half period 5; R5 idle level follows CPOL
      wr('h04, (1 << 12) | (1 << 11) | (1 << 5) | 'h15);
      @(negedge clk);
      check("R5 idle high", int'(spi_sck), 1);
      slave_word = 'h1234;
      wr('h08, 'hBEEF);
      repeat (7) @(negedge clk);
      wr('h08, 'h0000);           // R10 ignored mid-word
      while (m_busy != 0) @(negedge clk);
      rd("R10 rx intact", 'h0C, 'h1234);
      rd("R8 cause 16b", 'h10, 1);
      check("R11 mosi idle", int'(spi_mosi), 0);
      wr('h10, 0);

      // mode 1, 8 bit, code below floor clamps to divide by 4 (R4)
      wr('h04, (1 << 12) | 'h03);
      slave_word = 'h5A;
      timed_word("R4 clamp duration", 'hC3, 32);
      rd("R6 rx mode1", 'h0C, 'h5A);
      wr('h10, 0);

      // mode 2, 16 bit, largest divider (R4)
      wr('h04, (1 << 11) | (1 << 5) | 'h1F);
      slave_word = 'hF00D;
      timed_word("R4 max duration", 'h8001, 480);
      rd("R8 rx mode2", 'h0C, 'hF00D);
      @(negedge clk);
      check("R5 sck home", int'(spi_sck), 1);

      wr('h00, 0);
      check("R2 ss released", int'(spi_ss_n), 1);
      repeat (4) @(negedge clk);
      summary();
   end
endmodule